// File: doc/BRIEF.md
# FEC Rate Clock-Enable Generator

This block turns one fast reference clock into two gapped clock-enable strobes. Downstream logic uses them as slower clocks. When Reed-Solomon parity is inserted or stripped, the line rate grows or shrinks by a small fraction: 17/16 for a 7-byte-correcting code over 255-byte blocks, and 15/14 for an 8-byte-correcting code. A transmit strobe (the synthesiser path) and a receive strobe (the recovered-clock path) each pulse a fixed number of times per window of reference cycles. The ratio between the two strobes then equals the reciprocal divider pair picked by a 3-bit code select.

Each path holds a modulo-D accumulator. Every reference cycle it adds M and raises its strobe on overflow, so it produces exactly M pulses in D cycles, spaced as evenly as possible. A new select takes effect only when the current window closes. Codes that leave the receive divider unused instead raise a flag meaning that an external clock drives the receive side. With coding switched off, both strobes stay high.

Top module: `fec_ce_gen`

## Requirements
- R1: Right after reset, with no clock edge yet, `tx_ce` and `rx_ce` are 1 and `ext_clk_bypass` is 0. The first window after reset is one cycle long, so the select present at the first edge is taken up at that edge.
- R2: While `fec_on` is 0, both strobes are 1 in every cycle and `ext_clk_bypass` is 0, once the current windows have closed.
- R3: With `fec_on` = 1, the transmit divider is chosen as follows. `fec_mode[2]` = 0 picks the wide pair and `fec_mode[2]` = 1 picks the narrow pair. `fec_mode[0]` = 0 picks the odd member and `fec_mode[0]` = 1 picks the even member. This gives 17, 16, 15 or 14.
- R4: With `fec_on` = 1 and `fec_mode[1]` = 1, the receive divider is the other member of the same pair: 16 against 17, 17 against 16, 14 against 15, 15 against 14.
- R5: A divider X gives a strobe ratio M/D with D = X, and M = 16 when X is 16 or 17, or M = 14 when X is 14 or 15. Every window of D cycles contains exactly M strobes. For example, divider 17 gives 16 of 17 and divider 14 gives 14 of 14.
- R6: In cycle k of a window, counting from 0, the strobe is 1 exactly when floor((k+1)·M/D) differs from floor(k·M/D). For ratios below one, only cycle 0 of each window is idle.
- R7: With `fec_on` = 1 and `fec_mode[1]` = 0, `ext_clk_bypass` is 1 and `rx_ce` stays 0. The transmit strobe still follows R3 and R5.
- R8: A change of `fec_on` or `fec_mode` takes effect on a path only at the clock edge that closes that path's current window. Until then the old pattern continues, so no window is partial.
- R9: The two paths close their windows independently. A select change can reach the receive strobe and `ext_clk_bypass` while the transmit strobe is still finishing its old window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fec_on | input | 1 | 1 = coded operation, 0 = uncoded full rate |
| fec_mode | input | 3 | Code select: bit 2 = pair, bit 1 = receive divider in use, bit 0 = pair member |
| tx_ce | output | 1 | Transmit-path clock enable |
| rx_ce | output | 1 | Receive-path clock enable |
| ext_clk_bypass | output | 1 | Receive side runs from an external clock |

## Verification
Both strobes and the bypass flag are decoded from registered path state. Each therefore changes in the cycle right after the edge that updates that state. The bench drives inputs on falling edges and samples one falling edge after each rising edge. A select applied from the reset state is picked up at the first rising edge, and cycle 0 of the new window is visible half a period later. For a select changed in mid-window, the bench counts the remaining cycles of the old window itself. It expects the old pattern up to and including the window's last cycle, and the new pattern from the following cycle. Expected strobes come from the floor-difference formula of R6, evaluated in the bench per cycle index.

// File: rtl/fec_ce_pkg.sv
package fec_ce_pkg;

  parameter int unsigned RATIO_W     = 5;
  parameter int unsigned BASE_WIDE   = 16;
  parameter int unsigned BASE_NARROW = 14;

  localparam int unsigned NUM_PATHS = 2;
  localparam int unsigned PATH_TX   = 0;
  localparam int unsigned PATH_RX   = 1;

  typedef logic [RATIO_W-1:0] rval_t;

  // m strobes in every window of d reference cycles
  typedef struct packed {
    rval_t m;
    rval_t d;
  } ratio_t;

  localparam ratio_t RATIO_FULL = '{m: rval_t'(1), d: rval_t'(1)};
  localparam ratio_t RATIO_IDLE = '{m: rval_t'(0), d: rval_t'(1)};

  // divider -> strobe ratio: the even base of its pair over the divider
  function automatic ratio_t ratio_of_div(input rval_t div);
    ratio_t r;
    r.d = div;
    r.m = (div >= rval_t'(BASE_WIDE)) ? rval_t'(BASE_WIDE) : rval_t'(BASE_NARROW);
    return r;
  endfunction

  // bit 2 selects the pair, bit 0 the member taken by the transmit side
  function automatic rval_t tx_div_of(input logic [2:0] mode);
    if (mode[2]) return mode[0] ? rval_t'(BASE_NARROW) : rval_t'(BASE_NARROW + 1);
    else         return mode[0] ? rval_t'(BASE_WIDE)   : rval_t'(BASE_WIDE + 1);
  endfunction

  // receive side takes the other member of the same pair
  function automatic rval_t rx_div_of(input logic [2:0] mode);
    if (mode[2]) return mode[0] ? rval_t'(BASE_NARROW + 1) : rval_t'(BASE_NARROW);
    else         return mode[0] ? rval_t'(BASE_WIDE + 1)   : rval_t'(BASE_WIDE);
  endfunction

  function automatic logic uses_ext_clk(input logic [2:0] mode);
    return ~mode[1];
  endfunction

endpackage

// File: rtl/fec_ce_decode.sv
module fec_ce_decode
  import fec_ce_pkg::*;
(
  input  logic                        fec_on,
  input  logic [2:0]                  fec_mode,
  output ratio_t [NUM_PATHS-1:0]      next_ratio
);

  always_comb begin
    if (!fec_on) begin
      next_ratio[PATH_TX] = RATIO_FULL;
      next_ratio[PATH_RX] = RATIO_FULL;
    end else begin
      next_ratio[PATH_TX] = ratio_of_div(tx_div_of(fec_mode));
      next_ratio[PATH_RX] = uses_ext_clk(fec_mode) ? RATIO_IDLE
                                                   : ratio_of_div(rx_div_of(fec_mode));
    end
  end

endmodule

// File: rtl/fec_ce_accum.sv
module fec_ce_accum
  import fec_ce_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t next_i,
  output logic   ce_o,
  output logic   win_last_o,
  output ratio_t active_o
);

  localparam int unsigned SUM_W = RATIO_W + 1;

  ratio_t            act_q;
  logic [RATIO_W-1:0] phase_q;
  logic [RATIO_W-1:0] acc_q;
  logic [RATIO_W-1:0] en_cnt_q;
  logic [SUM_W-1:0]   sum;

  assign sum        = {1'b0, acc_q} + {1'b0, act_q.m};
  assign ce_o       = (sum >= {1'b0, act_q.d});
  assign win_last_o = (phase_q == act_q.d - rval_t'(1));
  assign active_o   = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= RATIO_FULL;
      phase_q  <= '0;
      acc_q    <= '0;
      en_cnt_q <= '0;
    end else if (win_last_o) begin
      act_q    <= next_i;
      phase_q  <= '0;
      acc_q    <= '0;
      en_cnt_q <= '0;
    end else begin
      phase_q  <= phase_q + rval_t'(1);
      acc_q    <= ce_o ? RATIO_W'(sum - {1'b0, act_q.d}) : RATIO_W'(sum);
      en_cnt_q <= en_cnt_q + rval_t'(ce_o);
    end
  end

  // R5
  win_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_last_o |-> ((SUM_W'(en_cnt_q) + SUM_W'(ce_o)) == SUM_W'(act_q.m)));

  // R6
  first_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == '0) && (act_q.m < act_q.d)) |-> !ce_o);

  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(win_last_o) |-> $stable(act_q));

  // R8
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < act_q.d);

endmodule

// File: rtl/fec_ce_gen.sv
module fec_ce_gen
  import fec_ce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fec_on,
  input  logic [2:0] fec_mode,
  output logic       tx_ce,
  output logic       rx_ce,
  output logic       ext_clk_bypass
);

  ratio_t [NUM_PATHS-1:0] next_ratio;
  ratio_t [NUM_PATHS-1:0] active_ratio;
  logic   [NUM_PATHS-1:0] path_ce;
  logic   [NUM_PATHS-1:0] path_win_last;

  fec_ce_decode u_decode (
    .fec_on     (fec_on),
    .fec_mode   (fec_mode),
    .next_ratio (next_ratio)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    fec_ce_accum u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .next_i     (next_ratio[p]),
      .ce_o       (path_ce[p]),
      .win_last_o (path_win_last[p]),
      .active_o   (active_ratio[p])
    );
  end

  assign tx_ce          = path_ce[PATH_TX];
  assign rx_ce          = path_ce[PATH_RX];
  assign ext_clk_bypass = (active_ratio[PATH_RX].m == '0);

  // R7
  bypass_rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clk_bypass |-> !rx_ce);

  // R2
  uncoded_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fec_on) && $past(path_win_last[PATH_TX])) |-> tx_ce);

  // R2
  uncoded_no_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fec_on) && $past(path_win_last[PATH_RX])) |-> (rx_ce && !ext_clk_bypass));

endmodule

// File: tb/fec_ce_gen_tb_top.sv
module fec_ce_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fec_on = 1'b0;
  logic [2:0] fec_mode = 3'b000;
  logic       tx_ce, rx_ce, ext_clk_bypass;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fec_ce_gen dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .fec_on         (fec_on),
    .fec_mode       (fec_mode),
    .tx_ce          (tx_ce),
    .rx_ce          (rx_ce),
    .ext_clk_bypass (ext_clk_bypass)
  );

  function automatic bit exp_en(int k, int m, int d);
    return (((k + 1) * m) / d) != ((k * m) / d);
  endfunction

  task automatic check(string req, string what, int act, int exp, int cyc);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    fec_on   = 1'b0;
    fec_mode = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state before any edge
    check("R1", "tx_ce", int'(tx_ce), 1, 0);
    check("R1", "rx_ce", int'(rx_ce), 1, 0);
    check("R1", "bypass", int'(ext_clk_bypass), 0, 0);
  endtask

  // from reset state the select is taken up at the first edge
  task automatic run_mode(string req, bit on, logic [2:0] mode,
                          int tm, int td, int rm, int rd, bit byp, int n);
    int tx_cnt = 0;
    do_reset();
    fec_on   = on;
    fec_mode = mode;
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      @(negedge clk);
      check(req, "tx_ce", int'(tx_ce), int'(exp_en(c % td, tm, td)), c);
      check(req, "rx_ce", int'(rx_ce), int'(exp_en(c % rd, rm, rd)), c);
      check(req, "bypass", int'(ext_clk_bypass), int'(byp), c);
      if (c < td) tx_cnt += int'(tx_ce);
    end
    // R5: strobes in the first transmit window
    check("R5", "tx window count", tx_cnt, tm, td);
  endtask

  // R8 / R9: change in mid-window of the transmit path
  task automatic run_change();
    do_reset();
    fec_on   = 1'b1;
    fec_mode = 3'b000;            // tx 16/17, receive external
    for (int c = 0; c < 5; c++) begin
      @(posedge clk);
      @(negedge clk);
      check("R8", "tx_ce", int'(tx_ce), int'(exp_en(c, 16, 17)), c);
      check("R7", "bypass", int'(ext_clk_bypass), 1, c);
    end
    fec_mode = 3'b111;            // tx 14/14, rx 14/15
    for (int c = 5; c < 60; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c < 17)
        check("R8", "tx_ce old window", int'(tx_ce), int'(exp_en(c, 16, 17)), c);
      else
        check("R8", "tx_ce new window", int'(tx_ce), int'(exp_en((c - 17) % 14, 14, 14)), c);
      check("R9", "rx_ce", int'(rx_ce), int'(exp_en((c - 5) % 15, 14, 15)), c);
      check("R9", "bypass", int'(ext_clk_bypass), 0, c);
    end
    // narrow pair member change: 14/14 -> 14/15 at a window close
    fec_mode = 3'b110;
    for (int c = 60; c < 100; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c < 73)
        check("R8", "tx_ce old 14/14", int'(tx_ce), 1, c);
      else
        check("R8", "tx_ce new 14/15", int'(tx_ce), int'(exp_en((c - 73) % 15, 14, 15)), c);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    run_mode("R2", 1'b0, 3'b010,  1,  1,  1,  1, 1'b0, 20);
    run_mode("R3", 1'b1, 3'b010, 16, 17, 16, 16, 1'b0, 40);
    run_mode("R4", 1'b1, 3'b011, 16, 16, 16, 17, 1'b0, 40);
    run_mode("R4", 1'b1, 3'b110, 14, 15, 14, 14, 1'b0, 40);
    run_mode("R6", 1'b1, 3'b111, 14, 14, 14, 15, 1'b0, 40);
    run_mode("R7", 1'b1, 3'b000, 16, 17,  0,  1, 1'b1, 40);
    run_mode("R7", 1'b1, 3'b001, 16, 16,  0,  1, 1'b1, 40);
    run_mode("R3", 1'b1, 3'b100, 14, 15,  0,  1, 1'b1, 40);
    run_mode("R3", 1'b1, 3'b101, 14, 14,  0,  1, 1'b1, 40);
    run_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule